// File: doc/BRIEF.md
# Segmentable Tapped Shift Register

This block stores a serial bit stream in a chain of static flip-flops that moves one place on every rising clock edge. Four tap ports sit at the end of each quarter of the chain (stages 16, 32, 48 and 64 with the default depth). A single mode input selects the chain's shape. With the mode input low, the chain is one long serial register and every tap port drives out the bit held at its stage. With the mode input high, every tap port releases its driver. The chain then breaks into four equal segments, and the first three tap ports become serial inputs to the heads of the second, third and fourth segments.

Each tap port is split into a value out, an enable out and a value in, so a pad ring can join them into a tri-state pin. The top level holds two channels that share nothing. Each channel has its own clock, serial input, mode input, test clear and taps. Contents persist with no reset. A synchronous clear is provided only so that a test can start from a known state.

Top module: `tapchain_dual`

## Requirements
- R1: On every rising edge of a channel's clock, the channel's serial input is captured into stage 1 (index 0), whatever the level of its mode input.
- R2: With the mode input low at the edge, every stage i>1 takes the previous content of stage i-1, so the chain behaves as one STAGES-long serial register and a bit entered at stage 1 reaches tap k (stage k*STAGES/TAPS) after k*STAGES/TAPS edges.
- R3: With the mode input low, all tap enables of that channel are 1.
- R4: With the mode input high, all tap enables of that channel are 0. Enables follow the mode input combinationally, with no clock edge needed.
- R5: With the mode input high at the edge, tap input bits 0, 1 and 2 are loaded into the head stages of segments 2, 3 and 4 (stages 17, 33, 49 by default) in place of the preceding stage's content. Stages inside a segment keep shifting.
- R6: Tap output bit k always carries the content of stage (k+1)*STAGES/TAPS, including while the enables are 0, and the last segment keeps shifting in split mode. Tap input bit TAPS-1 is never used.
- R7: With the mode input low, the tap input bits have no effect on the stored contents.
- R8: A change of the mode input with no clock edge leaves every stored stage and every tap output value unchanged.
- R9: A high test clear at a rising edge sets all stages of that channel to 0 and takes priority over the serial input and the tap inputs.
- R10: The two channels are independent: edges, inputs, mode and clear of one channel never change the other channel's stages or taps. Channel c uses bit c of each per-channel port and bits c*TAPS to c*TAPS+TAPS-1 of the tap buses.
- R11: When the mode input changes between edges in the middle of a stream, each edge uses the mode level present at that edge, so data stays continuous across each segment head when serial mode resumes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | NCH | Per-channel shift clock, rising edge active |
| clr | input | NCH | Per-channel synchronous test clear, active high |
| sin | input | NCH | Per-channel serial data into stage 1 |
| split | input | NCH | Per-channel mode: 0 one chain with taps driven, 1 four segments with taps released |
| tap_in | input | NCH*TAPS | Values seen on the tap pins, used as segment heads in split mode |
| tap_out | output | NCH*TAPS | Stage contents at each tap position |
| tap_oe | output | NCH*TAPS | Tap driver enables, 1 while driving |

## Verification
The case that needs the most care is a mode change that falls in the same cycle as a shift. The head of segments 2 to 4 must then choose between the previous stage and a tap input according to the mode level at that very edge, while the serial head keeps loading regardless. The bench toggles the mode input at random intervals of one to seven cycles while streaming random serial and tap data, and sometimes stops one channel's clock. After each edge it compares every tap against an array model updated with the mode level present at that edge. Separately, it toggles the mode with both clocks stopped and expects the enables to move at once while the tap values stay still.

// File: rtl/tapchain_lane.sv
module tapchain_lane #(
  parameter int STAGES = 64,
  parameter int TAPS   = 4
) (
  input  logic            clk,
  input  logic            clr,
  input  logic            sin,
  input  logic            split,
  input  logic [TAPS-1:0] tap_in,
  output logic [TAPS-1:0] tap_out,
  output logic [TAPS-1:0] tap_oe
);
  localparam int SEG = STAGES / TAPS;

  logic [STAGES-1:0] sr;
  logic [STAGES-1:0] nxt;
  logic              last_tap_unused;

  assign last_tap_unused = tap_in[TAPS-1];

  always_comb begin
    nxt = {sr[STAGES-2:0], sin};
    for (int k = 1; k < TAPS; k++)
      if (split) nxt[k*SEG] = tap_in[k-1];
  end

  always_ff @(posedge clk)
    sr <= clr ? '0 : nxt;

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    assign tap_out[k] = sr[(k+1)*SEG-1];
  end

  assign tap_oe = {TAPS{~split}};
endmodule

// File: rtl/tapchain_lane_chk.sv
module tapchain_lane_chk #(
  parameter int STAGES = 64,
  parameter int TAPS   = 4
) (
  input logic              clk,
  input logic              clr,
  input logic              sin,
  input logic              split,
  input logic [TAPS-1:0]   tap_in,
  input logic [STAGES-1:0] sr
);
  localparam int SEG = STAGES / TAPS;

  logic primed   = 1'b0;
  logic primed_d = 1'b0;

  always_ff @(posedge clk) begin
    if (clr) primed <= 1'b1;
    primed_d <= primed;
  end

  // R1
  head_load_chk: assert property (@(posedge clk) disable iff (clr)
    (primed_d && !$past(clr)) |-> sr[0] == $past(sin));

  // R9
  clear_zero_chk: assert property (@(posedge clk)
    clr |=> sr == '0);

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    if (i % SEG != 0) begin : g_inner
      // R2
      inner_shift_chk: assert property (@(posedge clk) disable iff (clr)
        (primed_d && !$past(clr)) |-> sr[i] == $past(sr[i-1]));
    end else begin : g_head
      // R2
      serial_join_chk: assert property (@(posedge clk) disable iff (clr)
        (primed_d && !$past(clr) && !$past(split)) |-> sr[i] == $past(sr[i-1]));
      // R5
      split_head_chk: assert property (@(posedge clk) disable iff (clr)
        (primed_d && !$past(clr) && $past(split)) |-> sr[i] == $past(tap_in[i/SEG-1]));
    end
  end
endmodule

bind tapchain_lane tapchain_lane_chk #(.STAGES(STAGES), .TAPS(TAPS)) u_lane_chk (
  .clk(clk), .clr(clr), .sin(sin), .split(split), .tap_in(tap_in), .sr(sr)
);

// File: rtl/tapchain_dual.sv
module tapchain_dual #(
  parameter int NCH    = 2,
  parameter int STAGES = 64,
  parameter int TAPS   = 4
) (
  input  logic [NCH-1:0]      clk,
  input  logic [NCH-1:0]      clr,
  input  logic [NCH-1:0]      sin,
  input  logic [NCH-1:0]      split,
  input  logic [NCH*TAPS-1:0] tap_in,
  output logic [NCH*TAPS-1:0] tap_out,
  output logic [NCH*TAPS-1:0] tap_oe
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tapchain_lane #(.STAGES(STAGES), .TAPS(TAPS)) u_lane (
      .clk    (clk[c]),
      .clr    (clr[c]),
      .sin    (sin[c]),
      .split  (split[c]),
      .tap_in (tap_in[c*TAPS +: TAPS]),
      .tap_out(tap_out[c*TAPS +: TAPS]),
      .tap_oe (tap_oe[c*TAPS +: TAPS])
    );
  end
endmodule

// File: tb/tapchain_dual_bench.sv
`timescale 1ns/1ps
module tapchain_dual_bench;
  localparam int NCH = 2, STAGES = 64, TAPS = 4, SEG = STAGES / TAPS;

  logic clk = 1'b0;
  logic [NCH-1:0] en = '1;
  logic [NCH-1:0] clk_l, clr, sin, split;
  logic [NCH*TAPS-1:0] tap_in, tap_out, tap_oe;
  logic [STAGES-1:0] m [NCH];
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;
  assign clk_l = {NCH{clk}} & en;

  tapchain_dual #(.NCH(NCH), .STAGES(STAGES), .TAPS(TAPS)) u_tapchain_dual (
    .clk(clk_l), .clr(clr), .sin(sin), .split(split),
    .tap_in(tap_in), .tap_out(tap_out), .tap_oe(tap_oe)
  );

  function automatic logic [STAGES-1:0] step(logic [STAGES-1:0] cur, logic d,
                                             logic sp, logic [TAPS-1:0] ti);
    logic [STAGES-1:0] r;
    r = {cur[STAGES-2:0], d};
    if (sp) for (int k = 1; k < TAPS; k++) r[k*SEG] = ti[k-1];
    return r;
  endfunction

  function automatic logic [TAPS-1:0] taps_of(logic [STAGES-1:0] v);
    logic [TAPS-1:0] t;
    for (int k = 0; k < TAPS; k++) t[k] = v[(k+1)*SEG-1];
    return t;
  endfunction

  always @(posedge clk)
    for (int c = 0; c < NCH; c++)
      if (en[c]) m[c] <= clr[c] ? '0 : step(m[c], sin[c], split[c], tap_in[c*TAPS +: TAPS]);

  task automatic chk(int c, string tag);
    logic [TAPS-1:0] et, eo;
    et = taps_of(m[c]);
    eo = {TAPS{~split[c]}};
    checks++;
    if (tap_out[c*TAPS +: TAPS] !== et) begin
      fails++;
      $display("FAIL %s ch%0d tap_out actual=%b expected=%b", tag, c, tap_out[c*TAPS +: TAPS], et);
    end
    checks++;
    if (tap_oe[c*TAPS +: TAPS] !== eo) begin
      fails++;
      $display("FAIL %s ch%0d tap_oe actual=%b expected=%b", tag, c, tap_oe[c*TAPS +: TAPS], eo);
    end
  endtask

  task automatic cyc(string tag);
    @(negedge clk);
    for (int c = 0; c < NCH; c++) chk(c, tag);
  endtask

  task automatic rnd_data();
    sin = NCH'($urandom);
    tap_in = (NCH*TAPS)'($urandom);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #4000000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4517));
    clr = '1; sin = '1; split = '0; tap_in = '1;
    // R9: clear on both channels from unknown contents
    cyc("R9");

    // R2 R3 R7: serial mode, random tap inputs must be ignored
    clr = '0;
    for (int n = 0; n < 150; n++) begin rnd_data(); cyc("R2 R3 R7"); end

    // R1 R4 R5 R6: split mode with random segment heads
    split = '1;
    for (int n = 0; n < 120; n++) begin rnd_data(); cyc("R1 R4 R5 R6"); end

    // R11 R10: mode flips mid-stream, channel 1 clock sometimes stopped
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 6) == 0) split[0] = ~split[0];
      if ($urandom_range(0, 4) == 0) split[1] = ~split[1];
      en[1] = ($urandom_range(0, 3) != 0);
      rnd_data();
      cyc("R11 R10");
    end
    en = '1;

    // R11 directed: serial continuity after a split burst, marker walks the full chain
    split = '0; sin = '0;
    cyc("R11");
    split = '1; sin = '1;
    cyc("R11");
    split = '0; sin = '0;
    for (int n = 0; n < STAGES + 2; n++) cyc("R11 R2");

    // R8 R4: mode changes with no clock edge
    en = '0;
    for (int n = 0; n < 6; n++) begin
      split = ~split;
      tap_in = (NCH*TAPS)'($urandom);
      #2;
      for (int c = 0; c < NCH; c++) chk(c, "R8 R4");
      cyc("R8");
    end
    en = '1;

    // R9: clear wins over serial and tap data in split mode
    rnd_data();
    split = '1; sin = '1; tap_in = '1; clr = '1;
    cyc("R9");
    clr = '0;
    for (int n = 0; n < 30; n++) begin rnd_data(); cyc("R1 R5"); end

    // R10: clear on channel 0 only while channel 1 keeps streaming
    split = 2'b10; clr = 2'b01;
    for (int n = 0; n < 20; n++) begin rnd_data(); cyc("R10 R9"); end
    clr = '0;
    for (int n = 0; n < 40; n++) begin
      en[0] = ($urandom_range(0, 1) == 1);
      rnd_data();
      cyc("R10");
    end
    en = '1;

    finish_run();
  end
endmodule